// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block decides which of six exception sources a processor core enters next. The sources are a reset request, a data abort, a fast interrupt, a normal interrupt, a prefetch abort and a software interrupt. Every cycle it picks the highest-ranked request that is allowed through the current masks. On the following cycle it reports the chosen exception code and updates the fast and normal interrupt masks. It also stores the program counter of the cycle in which the exception was taken into a link register that belongs to that exception's mode.

A return command names the mode being left. One cycle later the block presents a restored program counter: the mode's link value minus the adjustment that applies to that exception type. At the same moment it puts back the mask pair that was in force when the mode was entered. The two interrupt lines are asynchronous to the core and pass through a synchronizer of configurable depth before the priority logic sees them. All other sources are sampled directly.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several eligible requests are present in one cycle, the one taken is the highest in this ranking: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt. The reported code is 0, 1, 2, 3, 4 and 5 respectively.
- R2: A reset request is taken whatever the mask state, and its entry sets both the fast and the normal interrupt mask.
- R3: Entering the fast interrupt sets both masks. While the normal mask is set, an asserted normal interrupt is not taken.
- R4: Entering a data abort, normal interrupt, prefetch abort or software interrupt sets the normal mask and leaves the fast mask unchanged.
- R5: The link register of the entered mode captures `pc_cur` as sampled on the clock edge at which the exception is taken.
- R6: A return from the fast or the normal interrupt yields that mode's link value minus 4, modulo 2^AW.
- R7: A return from the software interrupt or from reset yields the link value unchanged. A return from the data abort yields link minus 8, and a return from the prefetch abort yields link minus 4.
- R8: A return restores the mask pair that was in force just before the returned-from mode was entered.
- R9: A masked interrupt request that stays asserted remains pending and is taken on the cycle after its mask clears.
- R10: A fast or normal interrupt is reported SYNC_STAGES+1 cycles after its raw input rises. The other sources are reported one cycle after they are sampled.
- R11: The block reset clears both masks, all link registers, the synchronizer and both output pulses.
- R12: `take_valid` is high for one cycle per exception taken, and `pc_valid` is high for one cycle per return command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| req_reset | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| fiq_async | input | 1 | Fast interrupt request, asynchronous |
| irq_async | input | 1 | Normal interrupt request, asynchronous |
| req_pabort | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| pc_cur | input | AW | Current program counter, saved on entry |
| ret_req | input | 1 | Return command |
| ret_kind | input | 3 | Code of the mode being left |
| take_valid | output | 1 | Exception entered this cycle |
| take_kind | output | 3 | Code of the entered exception |
| mask_fiq | output | 1 | Fast interrupt mask |
| mask_irq | output | 1 | Normal interrupt mask |
| pc_valid | output | 1 | Restored program counter is valid |
| pc_restore | output | AW | Restored program counter |

## Verification
The bench builds the block with AW = 16 and SYNC_STAGES = 3. The narrow address width puts the wrap of the return subtraction within reach: a fast interrupt taken at address 2 must return to 0xFFFE, and a data abort return after the links are cleared must give 0xFFF8. The three-stage synchronizer separates the interrupt latency clearly from the one-cycle latency of the directly sampled sources.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned EXC_COUNT = 6;
    localparam int unsigned KIND_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        EXC_RST  = 3'd0,
        EXC_DABT = 3'd1,
        EXC_FIQ  = 3'd2,
        EXC_IRQ  = 3'd3,
        EXC_PABT = 3'd4,
        EXC_SWI  = 3'd5
    } exc_kind_e;

    typedef struct packed {
        logic f;
        logic i;
    } mask_t;

    // amount subtracted from the saved link on return
    function automatic logic [3:0] ret_adjust(input logic [KIND_W-1:0] k);
        case (k)
            EXC_FIQ, EXC_IRQ, EXC_PABT: ret_adjust = 4'd4;
            EXC_DABT:                   ret_adjust = 4'd8;
            default:                    ret_adjust = 4'd0;
        endcase
    endfunction

    // mask pair after entering exception k from state cur
    function automatic mask_t entry_masks(input exc_kind_e k, input mask_t cur);
        mask_t m;
        m.i = 1'b1;
        m.f = cur.f | (k == EXC_RST) | (k == EXC_FIQ);
        return m;
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [EXC_COUNT-1:0] req,
    input  mask_t                mask,
    output logic                 grant_valid,
    output exc_kind_e            grant_kind
);
    logic [EXC_COUNT-1:0] elig;

    always_comb begin
        elig           = req;
        elig[EXC_FIQ]  = req[EXC_FIQ] & ~mask.f;
        elig[EXC_IRQ]  = req[EXC_IRQ] & ~mask.i;
        grant_valid    = |elig;
        grant_kind     = EXC_RST;
        // scan from lowest rank upward so the highest rank is written last
        for (int k = EXC_COUNT - 1; k >= 0; k--) begin
            if (elig[k]) grant_kind = exc_kind_e'(3'(k));
        end
    end
endmodule

// File: rtl/exc_link_bank.sv
module exc_link_bank
    import exc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  exc_kind_e         wr_kind,
    input  logic [AW-1:0]     wr_link,
    input  mask_t             wr_mask,
    input  logic [KIND_W-1:0] rd_kind,
    output logic [AW-1:0]     rd_link,
    output mask_t             rd_mask
);
    logic [AW-1:0] link_q [EXC_COUNT];
    mask_t         save_q [EXC_COUNT];

    for (genvar g = 0; g < EXC_COUNT; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst) begin
                link_q[g] <= '0;
                save_q[g] <= '0;
            end else if (wr_en && wr_kind == exc_kind_e'(3'(g))) begin
                link_q[g] <= wr_link;
                save_q[g] <= wr_mask;
            end
        end
    end

    always_comb begin
        rd_link = '0;
        rd_mask = '0;
        for (int k = 0; k < EXC_COUNT; k++) begin
            if (rd_kind == 3'(k)) begin
                rd_link = link_q[k];
                rd_mask = save_q[k];
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_reset,
    input  logic          req_dabort,
    input  logic          fiq_async,
    input  logic          irq_async,
    input  logic          req_pabort,
    input  logic          req_swi,
    input  logic [AW-1:0] pc_cur,
    input  logic          ret_req,
    input  logic [2:0]    ret_kind,
    output logic          take_valid,
    output logic [2:0]    take_kind,
    output logic          mask_fiq,
    output logic          mask_irq,
    output logic          pc_valid,
    output logic [AW-1:0] pc_restore
);
    logic                 fiq_s, irq_s;
    logic [EXC_COUNT-1:0] req_vec;
    logic                 grant_valid;
    exc_kind_e            grant_kind;
    logic [AW-1:0]        rd_link;
    mask_t                rd_mask;
    mask_t                mask_q, mask_d;

    exc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({irq_async, fiq_async}),
        .q   ({irq_s, fiq_s})
    );

    always_comb begin
        req_vec           = '0;
        req_vec[EXC_RST]  = req_reset;
        req_vec[EXC_DABT] = req_dabort;
        req_vec[EXC_FIQ]  = fiq_s;
        req_vec[EXC_IRQ]  = irq_s;
        req_vec[EXC_PABT] = req_pabort;
        req_vec[EXC_SWI]  = req_swi;
    end

    exc_arbiter u_arb (
        .req         (req_vec),
        .mask        (mask_q),
        .grant_valid (grant_valid),
        .grant_kind  (grant_kind)
    );

    exc_link_bank #(.AW(AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (grant_valid),
        .wr_kind (grant_kind),
        .wr_link (pc_cur),
        .wr_mask (mask_q),
        .rd_kind (ret_kind),
        .rd_link (rd_link),
        .rd_mask (rd_mask)
    );

    // a return restores first; an entry in the same cycle then sets its bits
    always_comb begin
        mask_d = mask_q;
        if (ret_req)     mask_d = rd_mask;
        if (grant_valid) mask_d = entry_masks(grant_kind, mask_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            take_valid <= 1'b0;
            take_kind  <= '0;
            pc_valid   <= 1'b0;
            pc_restore <= '0;
        end else begin
            mask_q     <= mask_d;
            take_valid <= grant_valid;
            take_kind  <= grant_kind;
            pc_valid   <= ret_req;
            pc_restore <= rd_link - AW'(ret_adjust(ret_kind));
        end
    end

    assign mask_fiq = mask_q.f;
    assign mask_irq = mask_q.i;

    p_reset_first_r1: assert property (@(posedge clk) disable iff (rst)
        $past(req_reset) |-> (take_valid && take_kind == EXC_RST));

    p_fiq_masks_both_r3: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_kind == EXC_FIQ) |-> (mask_fiq && mask_irq));

    p_irq_was_open_r3: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_kind == EXC_IRQ) |-> !$past(mask_irq));

    p_entry_sets_irq_mask_r4: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> mask_irq);

    p_restore_follows_cmd_r12: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> $past(ret_req));

    p_kind_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (take_kind < 3'(EXC_COUNT)));
endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
    localparam int AW   = 16;
    localparam int SYNC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_reset = 1'b0, req_dabort = 1'b0, fiq_async = 1'b0;
    logic          irq_async = 1'b0, req_pabort = 1'b0, req_swi = 1'b0;
    logic [AW-1:0] pc_cur = '0;
    logic          ret_req = 1'b0;
    logic [2:0]    ret_kind = '0;
    logic          take_valid, mask_fiq, mask_irq, pc_valid;
    logic [2:0]    take_kind;
    logic [AW-1:0] pc_restore;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst),
        .req_reset(req_reset), .req_dabort(req_dabort),
        .fiq_async(fiq_async), .irq_async(irq_async),
        .req_pabort(req_pabort), .req_swi(req_swi),
        .pc_cur(pc_cur), .ret_req(ret_req), .ret_kind(ret_kind),
        .take_valid(take_valid), .take_kind(take_kind),
        .mask_fiq(mask_fiq), .mask_irq(mask_irq),
        .pc_valid(pc_valid), .pc_restore(pc_restore)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_take(input string req, input int kind, input logic f, input logic i);
        chk(req, "take_valid", 32'(take_valid), 32'd1);
        chk(req, "take_kind", 32'(take_kind), 32'(kind));
        chk(req, "mask_fiq", 32'(mask_fiq), 32'(f));
        chk(req, "mask_irq", 32'(mask_irq), 32'(i));
    endtask

    task automatic do_return(input string req, input int kind, input int exp_pc);
        ret_req = 1'b1;
        ret_kind = 3'(kind);
        idle(1);
        ret_req = 1'b0;
        chk(req, "pc_valid", 32'(pc_valid), 32'd1);
        chk(req, "pc_restore", 32'(pc_restore), 32'(exp_pc));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        chk("R11", "take_valid after reset", 32'(take_valid), 32'd0);
        chk("R11", "mask_fiq after reset", 32'(mask_fiq), 32'd0);
        chk("R11", "mask_irq after reset", 32'(mask_irq), 32'd0);
        chk("R11", "pc_valid after reset", 32'(pc_valid), 32'd0);
        do_return("R11", 5, 0);
        idle(1);
        chk("R12", "pc_valid drops", 32'(pc_valid), 32'd0);
    endtask

    task automatic t_fiq_irq;
        pc_cur = 16'h0040;
        fiq_async = 1'b1;
        irq_async = 1'b1;
        idle(SYNC);
        chk("R10", "no take before sync", 32'(take_valid), 32'd0);
        idle(1);
        chk_take("R3", 2, 1'b1, 1'b1);
        pc_cur = 16'h0080;
        fiq_async = 1'b0;
        idle(SYNC + 2);
        chk("R3", "irq held off by mask", 32'(take_valid), 32'd0);
        do_return("R6", 2, 16'h003C);
        chk("R8", "mask_fiq restored", 32'(mask_fiq), 32'd0);
        chk("R8", "mask_irq restored", 32'(mask_irq), 32'd0);
        idle(1);
        chk_take("R9", 3, 1'b0, 1'b1);
        chk("R12", "pc_valid one cycle", 32'(pc_valid), 32'd0);
        irq_async = 1'b0;
        idle(1);
        chk("R12", "take_valid one cycle", 32'(take_valid), 32'd0);
        idle(SYNC);
        do_return("R6", 3, 16'h007C);
        chk("R8", "mask_irq after irq return", 32'(mask_irq), 32'd0);
    endtask

    task automatic t_prio;
        pc_cur = 16'h0200;
        req_dabort = 1'b1;
        req_pabort = 1'b1;
        req_swi = 1'b1;
        idle(1);
        chk_take("R1", 1, 1'b0, 1'b1);
        req_dabort = 1'b0;
        pc_cur = 16'h0300;
        idle(1);
        chk_take("R4", 4, 1'b0, 1'b1);
        req_pabort = 1'b0;
        pc_cur = 16'h0400;
        idle(1);
        chk_take("R1", 5, 1'b0, 1'b1);
        req_swi = 1'b0;
        idle(1);
        chk("R12", "no take when idle", 32'(take_valid), 32'd0);
        do_return("R7", 5, 16'h0400);
        do_return("R7", 4, 16'h02FC);
        do_return("R7", 1, 16'h01F8);
        chk("R8", "mask_irq back to open", 32'(mask_irq), 32'd0);
        chk("R5", "link of dabt kept", 32'(pc_restore), 32'h01F8);
    endtask

    task automatic t_reset_req;
        pc_cur = 16'h0500;
        req_reset = 1'b1;
        req_dabort = 1'b1;
        req_swi = 1'b1;
        idle(1);
        chk_take("R2", 0, 1'b1, 1'b1);
        req_reset = 1'b0;
        req_dabort = 1'b0;
        req_swi = 1'b0;
        idle(1);
        do_return("R7", 0, 16'h0500);
        chk("R8", "mask_fiq after reset-mode return", 32'(mask_fiq), 32'd0);
    endtask

    task automatic t_wrap;
        pc_cur = 16'h0002;
        fiq_async = 1'b1;
        idle(SYNC + 1);
        chk_take("R10", 2, 1'b1, 1'b1);
        fiq_async = 1'b0;
        idle(SYNC);
        do_return("R6", 2, 16'hFFFE);
    endtask

    task automatic t_block_reset;
        pc_cur = 16'h0600;
        req_dabort = 1'b1;
        idle(1);
        req_dabort = 1'b0;
        chk_take("R4", 1, 1'b0, 1'b1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk("R11", "mask_irq cleared", 32'(mask_irq), 32'd0);
        chk("R11", "take_valid cleared", 32'(take_valid), 32'd0);
        do_return("R11", 1, 16'hFFF8);
    endtask

    initial begin
        #(5.0 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_fiq_irq();
        t_prio();
        t_reset_req();
        t_wrap();
        t_block_reset();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule